// File: doc/BRIEF.md
# Dual-Slope PWM Timer

An 8-bit timer/counter with a clock prescaler and two compare channels. In its straight counting mode the counter runs upward and wraps from all ones to zero. In its two symmetric modes it climbs from zero to a ceiling and then descends back to zero. The ceiling is either all ones or the active value of compare channel A. Each channel drives one waveform output. A compare match changes that output in a direction that depends on which way the counter is heading, which yields centre-aligned PWM.

Software reaches the block through a small register bus. The bus writes the counter, writes the two compare buffers, clears flags and reads any of these back. Compare values are double-buffered. In the symmetric modes a new value takes effect only when the counter turns at its ceiling, so a period is never cut short. The prescaler selection, counting mode and per-channel output behaviour are static inputs driven by surrounding control logic.

Top module: `phase_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the three flags are 0 and both waveform outputs are low.
- R2: `clk_sel` picks the counting rate: 0 stops the counter, 1 advances it once per clock, and 2, 3, 4, 5, 6, 7 advance it once every 8, 32, 64, 128, 256 and 1024 clocks.
- R3: A bus write to address 0 loads the counter and overrides any count due in that clock. Bus addresses are 0 for the counter, 1 for compare buffer A, 2 for compare buffer B and 3 for the flags. `rd_data` returns the addressed register one clock after `rd_addr` is presented.
- R4: With `wave_mode` 1 (ceiling all ones) or 2 (ceiling equal to compare A), the counter climbs from 0 to the ceiling, holds the ceiling value for exactly one count step, descends to 0, holds 0 for one step and climbs again. `wave_mode` 0 or 3 selects straight counting.
- R5: In straight counting the counter increments and wraps from 0xFF to 0x00.
- R6: The overflow flag is set on the clock edge on which counting brings the counter to 0, in both counting styles.
- R7: A compare flag is set by the count step that consumes the matching counter value. Writing address 3 clears every flag whose bit is 1 (bit 0 overflow, bit 1 channel A, bit 2 channel B) and leaves the others unchanged.
- R8: Output mode 0 holds the output low. In the symmetric modes, mode 2 clears the output on a match while rising and sets it on a match while falling, and mode 3 does the reverse.
- R9: With a compare value of 0, a mode 2 output stays low and a mode 3 output stays high. With a compare value equal to the ceiling, a mode 2 output stays high.
- R10: In the symmetric modes a compare buffer write reaches the active compare value only at the ceiling turn. In straight counting it takes effect on the next clock.
- R11: With `wave_mode` 2 and output mode 1, channel A toggles at every ceiling match, which gives equal high and low times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | 2 | Bus read address |
| rd_data | output | 8 | Registered read data |
| clk_sel | input | 3 | Prescaler selection |
| wave_mode | input | 2 | Counting style and ceiling source |
| out_mode_a | input | 2 | Output behaviour of channel A |
| out_mode_b | input | 2 | Output behaviour of channel B |
| pwm_a | output | 1 | Waveform output A |
| pwm_b | output | 1 | Waveform output B |
| ovf_flag | output | 1 | Counter reached zero |
| cmp_flag_a | output | 1 | Channel A matched |
| cmp_flag_b | output | 1 | Channel B matched |

## Verification
Waveform outputs, flags and the counter all change on the same rising edge that consumes a count step. Register reads appear one edge after the address. The bench advances the counter one step at a time: it raises `clk_sel` to 1 for exactly one edge and then checks outputs and flags on the following falling edge. It reads the counter one further edge later, while counting is stopped so the value cannot move. Prescaler rates are measured over windows that span a whole multiple of each division, so the expected count does not depend on the divider's phase.

// File: rtl/pctmr_pkg.sv
package pctmr_pkg;
  typedef enum logic [1:0] {
    WM_STRAIGHT = 2'd0,
    WM_SYM_FULL = 2'd1,
    WM_SYM_CMPA = 2'd2,
    WM_SPARE    = 2'd3
  } wave_mode_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  localparam logic [1:0] ADDR_CNT   = 2'd0;
  localparam logic [1:0] ADDR_CMPA  = 2'd1;
  localparam logic [1:0] ADDR_CMPB  = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  // log2 of the division picked by a clock-select code (code 0 and 1: none)
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pctmr_prescaler.sv
module pctmr_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  import pctmr_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   span_m1;
  logic [PRE_W-1:0] mask;
  logic             run;

  assign run = (sel != 3'd0);

  always_comb begin
    span    = (PRE_W+1)'(1) << div_shift(sel);
    span_m1 = span - 1'b1;
    mask    = span_m1[PRE_W-1:0];
  end

  // a step is due whenever the selected low bits of the free counter are all ones
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pctmr_counter.sv
module pctmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         pc_en,
  input  logic [W-1:0] top_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_val,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt_q,
  output logic         evt,
  output logic         eff_up,
  output logic         turn_top,
  output logic         bot_hit,
  output logic         ovf_q
);
  localparam logic [W-1:0] BOT = '0;
  localparam logic [W-1:0] ONE = W'(1);

  logic         dir_up_q;
  logic [W-1:0] cnt_nxt;
  logic         dir_nxt;
  logic         at_turn;

  assign evt = tick && !cnt_wr;

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_up_q;
    at_turn = 1'b0;
    if (!pc_en) begin
      cnt_nxt = cnt_q + 1'b1;
      dir_nxt = 1'b1;
    end else if (dir_up_q) begin
      if (cnt_q >= top_val) begin
        at_turn = 1'b1;
        dir_nxt = 1'b0;
        cnt_nxt = (cnt_q == BOT) ? BOT : cnt_q - 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == BOT) begin
        dir_nxt = 1'b1;
        cnt_nxt = (top_val == BOT) ? BOT : ONE;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  // heading the counter takes after this step; the bottom step counts as rising
  assign eff_up   = !pc_en || (dir_up_q && (cnt_q < top_val)) || (!dir_up_q && (cnt_q == BOT));
  assign turn_top = evt && pc_en && at_turn;
  assign bot_hit  = evt && (cnt_nxt == BOT) && (cnt_q != BOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= BOT;
      dir_up_q <= 1'b1;
      ovf_q    <= 1'b0;
    end else begin
      if (cnt_wr)   cnt_q <= wr_val;
      else if (evt) cnt_q <= cnt_nxt;

      if (!pc_en)   dir_up_q <= 1'b1;
      else if (evt) dir_up_q <= dir_nxt;

      if (bot_hit)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pctmr_cmp_chan.sv
module pctmr_cmp_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_wr,
  input  logic [W-1:0] wr_val,
  input  logic         evt,
  input  logic [W-1:0] cnt,
  input  logic         eff_up,
  input  logic         pc_en,
  input  logic         top_load,
  input  logic [1:0]   out_mode,
  input  logic         toggle_ok,
  input  logic         flag_clr,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         flag_q,
  output logic         pwm_q
);
  import pctmr_pkg::*;

  out_mode_e om;
  logic      match;
  logic      load;
  logic      pwm_nxt;

  assign om    = out_mode_e'(out_mode);
  assign match = evt && (cnt == act_q);
  assign load  = pc_en ? top_load : 1'b1;

  always_comb begin
    pwm_nxt = pwm_q;
    case (om)
      OM_OFF:    pwm_nxt = 1'b0;
      OM_TOGGLE: begin
        if (!toggle_ok) pwm_nxt = 1'b0;
        else if (match) pwm_nxt = !pwm_q;
      end
      OM_NONINV: if (match) pwm_nxt = pc_en ? !eff_up : 1'b0;
      OM_INV:    if (match) pwm_nxt = pc_en ? eff_up : 1'b1;
      default:   pwm_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      act_q  <= '0;
      flag_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (buf_wr) buf_q <= wr_val;
      if (load)   act_q <= buf_q;
      if (match)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      pwm_q <= pwm_nxt;
    end
  end
endmodule

// File: rtl/phase_pwm_timer.sv
module phase_pwm_timer #(
  parameter int W     = 8,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [2:0]   clk_sel,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         ovf_flag,
  output logic         cmp_flag_a,
  output logic         cmp_flag_b
);
  import pctmr_pkg::*;

  localparam int NCH = 2;

  wave_mode_e   wm;
  logic         pc_en;
  logic         top_from_a;
  logic [W-1:0] top_val;
  logic         tick;
  logic         evt;
  logic         eff_up;
  logic         turn_top;
  logic         bot_hit;
  logic         ovf_q;
  logic [W-1:0] cnt_q;
  logic         cnt_wr;
  logic         flag_wr;

  logic [W-1:0]   buf_v [NCH];
  logic [W-1:0]   act_v [NCH];
  logic [1:0]     om_v  [NCH];
  logic [NCH-1:0] flag_v;
  logic [NCH-1:0] pwm_v;
  logic [NCH-1:0] buf_wr;
  logic [NCH-1:0] flag_clr;
  logic [NCH-1:0] tog_ok;
  logic [W-1:0]   rd_q;

  assign wm         = wave_mode_e'(wave_mode);
  assign pc_en      = (wm == WM_SYM_FULL) || (wm == WM_SYM_CMPA);
  assign top_from_a = (wm == WM_SYM_CMPA);
  assign top_val    = top_from_a ? act_v[0] : '1;
  assign cnt_wr     = wr_en && (wr_addr == ADDR_CNT);
  assign flag_wr    = wr_en && (wr_addr == ADDR_FLAGS);
  assign om_v[0]    = out_mode_a;
  assign om_v[1]    = out_mode_b;

  pctmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .sel (clk_sel),
    .tick(tick)
  );

  pctmr_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pc_en   (pc_en),
    .top_val (top_val),
    .cnt_wr  (cnt_wr),
    .wr_val  (wr_data),
    .ovf_clr (flag_wr && wr_data[0]),
    .cnt_q   (cnt_q),
    .evt     (evt),
    .eff_up  (eff_up),
    .turn_top(turn_top),
    .bot_hit (bot_hit),
    .ovf_q   (ovf_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign buf_wr[i]   = wr_en && (wr_addr == 2'(ADDR_CMPA + i));
    assign flag_clr[i] = flag_wr && wr_data[1+i];
    // only channel A may toggle while the ceiling is its own compare value
    assign tog_ok[i]   = !pc_en || ((i == 0) && top_from_a);

    pctmr_cmp_chan #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .buf_wr   (buf_wr[i]),
      .wr_val   (wr_data),
      .evt      (evt),
      .cnt      (cnt_q),
      .eff_up   (eff_up),
      .pc_en    (pc_en),
      .top_load (turn_top),
      .out_mode (om_v[i]),
      .toggle_ok(tog_ok[i]),
      .flag_clr (flag_clr[i]),
      .buf_q    (buf_v[i]),
      .act_q    (act_v[i]),
      .flag_q   (flag_v[i]),
      .pwm_q    (pwm_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        ADDR_CNT:  rd_q <= cnt_q;
        ADDR_CMPA: rd_q <= buf_v[0];
        ADDR_CMPB: rd_q <= buf_v[1];
        default:   rd_q <= {{(W-3){1'b0}}, flag_v[1], flag_v[0], ovf_q};
      endcase
    end
  end

  assign rd_data    = rd_q;
  assign pwm_a      = pwm_v[0];
  assign pwm_b      = pwm_v[1];
  assign ovf_flag   = ovf_q;
  assign cmp_flag_a = flag_v[0];
  assign cmp_flag_b = flag_v[1];
endmodule

// File: rtl/pctmr_checker.sv
module pctmr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   clk_sel,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt_q,
  input logic         evt,
  input logic         pc_en,
  input logic [W-1:0] top_val,
  input logic         bot_hit,
  input logic         ovf_flag,
  input logic [1:0]   out_mode_a,
  input logic         pwm_a
);
  // R2: a stopped prescaler freezes the counter
  p_stop_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 && !(wr_en && wr_addr == 2'd0)) |=> $stable(cnt_q));

  // R3: a bus write lands in the counter regardless of counting
  p_cpu_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> (cnt_q == $past(wr_data)));

  // R4: a step taken at the ceiling always leads one below it
  p_ceiling_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (evt && pc_en && cnt_q == top_val && top_val != '0) |=> ((cnt_q + 1'b1) == $past(cnt_q)));

  // R6: overflow rises only together with a zero count
  p_ovf_at_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (cnt_q == '0));

  // R7: write-one clears the overflow flag when no new bottom arrives
  p_ovf_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3 && wr_data[0] && !bot_hit) |=> !ovf_flag);

  // R8: output mode 0 drives the output low
  p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
    (out_mode_a == 2'd0) |=> !pwm_a);
endmodule

bind phase_pwm_timer pctmr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_sel   (clk_sel),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cnt_q     (cnt_q),
  .evt       (evt),
  .pc_en     (pc_en),
  .top_val   (top_val),
  .bot_hit   (bot_hit),
  .ovf_flag  (ovf_flag),
  .out_mode_a(out_mode_a),
  .pwm_a     (pwm_a)
);

// File: tb/phase_pwm_timer_tb.sv
module phase_pwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  // one row per single count step: {counter after, pwm_a, pwm_b, ovf, flag_a, flag_b}
  localparam logic [12:0] SYM_SEQ [15] = '{
    {8'd1, 5'b00000}, {8'd2, 5'b00000}, {8'd3, 5'b00001}, {8'd4, 5'b00001},
    {8'd5, 5'b00001}, {8'd6, 5'b00001}, {8'd5, 5'b10011}, {8'd4, 5'b10011},
    {8'd3, 5'b10011}, {8'd2, 5'b10011}, {8'd1, 5'b11011}, {8'd0, 5'b11111},
    {8'd1, 5'b11111}, {8'd2, 5'b11111}, {8'd3, 5'b10111}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [2:0]   clk_sel = '0;
  logic [1:0]   wave_mode = '0;
  logic [1:0]   out_mode_a = '0;
  logic [1:0]   out_mode_b = '0;
  logic         pwm_a, pwm_b, ovf_flag, cmp_flag_a, cmp_flag_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] rv;
  logic p0;

  phase_pwm_timer #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .ovf_flag(ovf_flag), .cmp_flag_a(cmp_flag_a), .cmp_flag_b(cmp_flag_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) begin
      clk_sel = 3'd1;
      @(negedge clk);
    end
    clk_sel = 3'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic run_sel(input logic [2:0] s, input int clocks);
    clk_sel = s;
    repeat (clocks) @(negedge clk);
    clk_sel = 3'd0;
  endtask

  // load compare buffers in straight mode, then restart from zero in a symmetric mode
  task automatic setup_sym(input logic [W-1:0] ca, input logic [W-1:0] cb);
    wave_mode = 2'd0; out_mode_a = 2'd0; out_mode_b = 2'd0;
    wr(2'd1, ca);
    wr(2'd2, cb);
    @(negedge clk);
    wr(2'd0, 8'd0);
    wave_mode = 2'd2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    chk("R1 flags", {ovf_flag, cmp_flag_a, cmp_flag_b}, 0);
    rd(2'd0, rv); chk("R1 counter", rv, 0);

    // R4 R6 R7 R8 R9: symmetric walk, ceiling = A = 6, B = 2, both non-inverting
    wr(2'd1, 8'd6);
    wr(2'd2, 8'd2);
    @(negedge clk);
    wave_mode = 2'd2; out_mode_a = 2'd2; out_mode_b = 2'd2;
    for (int i = 0; i < 15; i++) begin
      steps(1);
      chk($sformatf("R8 pwm_a row %0d", i), pwm_a, SYM_SEQ[i][4]);
      chk($sformatf("R8 pwm_b row %0d", i), pwm_b, SYM_SEQ[i][3]);
      chk($sformatf("R6 ovf row %0d", i), ovf_flag, SYM_SEQ[i][2]);
      chk($sformatf("R7 flag_a row %0d", i), cmp_flag_a, SYM_SEQ[i][1]);
      chk($sformatf("R7 flag_b row %0d", i), cmp_flag_b, SYM_SEQ[i][0]);
      rd(2'd0, rv);
      chk($sformatf("R4 count row %0d", i), rv, int'(SYM_SEQ[i][12:5]));
    end

    // R7 write-one-to-clear, selective
    wr(2'd3, 8'h01);
    chk("R7 ovf cleared", ovf_flag, 0);
    chk("R7 flag_a kept", cmp_flag_a, 1);
    chk("R7 flag_b kept", cmp_flag_b, 1);
    rd(2'd3, rv); chk("R3 flag readback", rv, 6);
    wr(2'd3, 8'h06);
    chk("R7 all cleared", {ovf_flag, cmp_flag_a, cmp_flag_b}, 0);

    // R3 bus write beats a count in the same clock
    wave_mode = 2'd0; out_mode_a = 2'd0; out_mode_b = 2'd0;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h40; clk_sel = 3'd1;
    @(negedge clk);
    wr_en = 1'b0; clk_sel = 3'd0;
    rd(2'd0, rv); chk("R3 write priority", rv, 8'h40);
    steps(1);
    rd(2'd0, rv); chk("R3 counts after write", rv, 8'h41);

    // R2 prescaler rates over whole windows
    wr(2'd0, 8'd0);
    run_sel(3'd2, 64);   rd(2'd0, rv); chk("R2 div8", rv, 8);
    run_sel(3'd3, 256);  rd(2'd0, rv); chk("R2 div32", rv, 16);
    run_sel(3'd7, 2048); rd(2'd0, rv); chk("R2 div1024", rv, 18);
    run_sel(3'd0, 40);   rd(2'd0, rv); chk("R2 stopped", rv, 18);
    run_sel(3'd1, 5);    rd(2'd0, rv); chk("R2 div1", rv, 23);
    run_sel(3'd4, 128);  rd(2'd0, rv); chk("R2 div64", rv, 25);
    run_sel(3'd5, 256);  rd(2'd0, rv); chk("R2 div128", rv, 27);
    run_sel(3'd6, 512);  rd(2'd0, rv); chk("R2 div256", rv, 29);

    // R5 R6 straight wrap; R10 R7 straight-mode compare takes effect next clock
    wr(2'd3, 8'h07);
    wr(2'd0, 8'hFE);
    steps(1);
    chk("R6 no ovf at FF", ovf_flag, 0);
    steps(1);
    chk("R6 ovf on wrap", ovf_flag, 1);
    rd(2'd0, rv); chk("R5 wrapped to 0", rv, 0);
    wr(2'd1, 8'h10);
    @(negedge clk);
    wr(2'd0, 8'h0F);
    steps(1);
    chk("R7 no flag before match", cmp_flag_a, 0);
    steps(1);
    chk("R10 straight compare live", cmp_flag_a, 1);

    // R9 compare at bottom: inverting high, then non-inverting low; R8 off channel low
    setup_sym(8'd4, 8'd0);
    out_mode_b = 2'd3;
    for (int i = 0; i < 16; i++) begin
      steps(1);
      chk($sformatf("R9 inverted bottom high %0d", i), pwm_b, 1);
      chk($sformatf("R8 off low %0d", i), pwm_a, 0);
    end
    out_mode_b = 2'd2;
    for (int i = 0; i < 8; i++) begin
      steps(1);
      chk($sformatf("R9 bottom low %0d", i), pwm_b, 0);
    end

    // R10 buffered compare reaches active value only at the ceiling
    setup_sym(8'd6, 8'd2);
    out_mode_b = 2'd2;
    steps(8);
    wr(2'd2, 8'd4);
    rd(2'd2, rv); chk("R3 buffer readback", rv, 4);
    steps(1); chk("R10 old value at 4 down", pwm_b, 0);
    steps(2); chk("R10 old value at 2 down", pwm_b, 1);
    steps(4); chk("R10 old value at 2 up", pwm_b, 0);
    steps(6); chk("R10 new value at 4 down", pwm_b, 1);

    // R11 toggle at ceiling, equal halves
    setup_sym(8'd3, 8'd0);
    out_mode_a = 2'd1;
    p0 = pwm_a;
    steps(3); chk("R11 before ceiling", pwm_a, p0);
    steps(1); chk("R11 first toggle", pwm_a, !p0);
    steps(5); chk("R11 held half period", pwm_a, !p0);
    steps(1); chk("R11 second toggle", pwm_a, p0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule